// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block decides, for a group of differential clock output pairs, whether each leg of each pair is enabled, and whether it toggles or is held at a fixed high level. It watches an asynchronous power-down pin and acts only once the request has been seen on two consecutive rising edges of the output clock, following a two-flop synchronizer. Every change is then applied on the next falling edge of that clock. A configuration bit sets how the outputs are parked. In one mode the true leg is held high and the complement leg is released. In the other mode both legs are released. A second configuration bit sets the active level of the pin.

When the request is withdrawn, the outputs do not resume toggling right away. The block enters a wake phase and waits for the clock source to report lock. It then lets a settle counter run out before clocks are allowed through. In the mode that releases both legs, the wake phase drives every leg high straight away, so no output floats while the source recovers. A wake counter bounds the whole recovery. If lock has not arrived when that counter expires, a sticky timeout flag is raised.

Top module: `clkout_pd_seq`

## Requirements
- R1: The pin passes through two flops. A request is acted on only after the synchronized request is seen on two consecutive rising edges, so a pin pulse that lasts a single clock cycle has no effect on the outputs.
- R2: After an assertion or withdrawal of the pin, set up just after a falling edge, the new output state appears on the falling edge that follows the fourth rising edge. Just after that fourth rising edge, the outputs still show the old state.
- R3: Parked with park_float = 0, each pair reads tru_oe=1, tru_hi=1, cmp_oe=0, cmp_hi=0.
- R4: Parked with park_float = 1, all four signals of every pair are 0.
- R5: With pd_active_high = 1, a high pin requests power-down. With pd_active_high = 0, a low pin requests it.
- R6: During wake and settle with park_float = 0, the outputs keep the R3 pattern. With park_float = 1, every pair reads tru_oe=cmp_oe=tru_hi=cmp_hi=1.
- R7: Running outputs appear only after lock is seen in the wake phase and SETTLE_CYC further rising edges have passed. With lock held high, the run pattern appears on the falling edge after rising edge SETTLE_CYC+1, counted from the wake entry edge. Losing lock during settle returns the block to waiting.
- R8: wake_timeout rises WAKE_MAX_CYC rising edges after wake entry if lock is never seen. It stays high until the next release, which clears it.
- R9: A synchronous active-high reset puts the block in the parked state for the current park mode, with the pin treated as requesting power-down.
- R10: The running pattern is tru_oe=cmp_oe=1 and tru_hi=cmp_hi=0. All pairs carry identical values and change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; decisions on rising edges, outputs on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| pd_pin | input | 1 | Asynchronous power-down request pin |
| park_float | input | 1 | 0: park with true leg held high; 1: release both legs |
| pd_active_high | input | 1 | 1: pin active high; 0: pin active low |
| pll_locked | input | 1 | Clock source lock indication, synchronous to clk |
| tru_oe | output | PAIRS | True-leg output enable per pair |
| cmp_oe | output | PAIRS | Complement-leg output enable per pair |
| tru_hi | output | PAIRS | Hold true leg at high level instead of toggling |
| cmp_hi | output | PAIRS | Hold complement leg at high level instead of toggling |
| wake_timeout | output | 1 | Lock did not arrive within the wake bound |

## Verification
Some properties are checked by assertions on every cycle:
- the output pattern that belongs to each settled state in each park mode;
- that a new park state is preceded by two qualified request samples;
- that settle begins only with lock present;
- that the timeout never rises while lock is present;
- that all pairs agree.

Other behaviours only the bench scenarios can show:
- the exact edge on which the outputs move, and that this is a falling edge;
- rejection of a one-cycle pin pulse;
- the exact settle and timeout cycle counts;
- the pin polarity;
- the return to waiting when lock drops during settle.

// File: rtl/clkout_pd_pkg.sv
package clkout_pd_pkg;

    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_WAKE   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic toe;
        logic coe;
        logic thi;
        logic chi;
    } leg_drive_t;

    localparam leg_drive_t DRV_RUN     = '{toe: 1'b1, coe: 1'b1, thi: 1'b0, chi: 1'b0};
    localparam leg_drive_t DRV_PARK_HI = '{toe: 1'b1, coe: 1'b0, thi: 1'b1, chi: 1'b0};
    localparam leg_drive_t DRV_FLOAT   = '{toe: 1'b0, coe: 1'b0, thi: 1'b0, chi: 1'b0};
    localparam leg_drive_t DRV_ALL_HI  = '{toe: 1'b1, coe: 1'b1, thi: 1'b1, chi: 1'b1};

    function automatic leg_drive_t park_drive(input logic float_mode);
        return float_mode ? DRV_FLOAT : DRV_PARK_HI;
    endfunction

    function automatic leg_drive_t drive_for(input seq_state_t st, input logic float_mode);
        leg_drive_t d;
        case (st)
            ST_PARK:   d = park_drive(float_mode);
            ST_WAKE,
            ST_SETTLE: d = float_mode ? DRV_ALL_HI : DRV_PARK_HI;
            default:   d = DRV_RUN;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkout_pd_sync.sv
module clkout_pd_sync (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_sync
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= req_async;
            sync_q <= meta_q;
        end
    end

    assign req_sync = sync_q;
endmodule

// File: rtl/clkout_pd_fsm.sv
module clkout_pd_fsm
    import clkout_pd_pkg::*;
#(
    parameter int WAKE_MAX_CYC = 100000,
    parameter int SETTLE_CYC   = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_sync,
    input  logic       pll_locked,
    output seq_state_t state,
    output logic       timeout
);
    localparam int WCW = (WAKE_MAX_CYC > 2) ? $clog2(WAKE_MAX_CYC) : 1;
    localparam int SCW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WAKE_MAX_CYC - 1);
    localparam logic [SCW-1:0] SLAST = SCW'(SETTLE_CYC - 1);

    seq_state_t     state_q;
    logic           req_prev;
    logic [WCW-1:0] wcnt;
    logic [SCW-1:0] scnt;
    logic           tmo_q;
    logic           qual_on;
    logic           qual_off;

    assign qual_on  = req_sync & req_prev;
    assign qual_off = ~req_sync & ~req_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_PARK;
            req_prev <= 1'b1;
            wcnt     <= '0;
            scnt     <= '0;
            tmo_q    <= 1'b0;
        end else begin
            req_prev <= req_sync;
            if (state_q != ST_RUN && state_q != ST_PARK && wcnt != WLAST)
                wcnt <= wcnt + 1'b1;
            case (state_q)
                ST_PARK: begin
                    if (qual_off) begin
                        state_q <= ST_WAKE;
                        wcnt    <= '0;
                        tmo_q   <= 1'b0;
                    end
                end
                ST_WAKE: begin
                    if (qual_on) begin
                        state_q <= ST_PARK;
                    end else if (pll_locked) begin
                        state_q <= ST_SETTLE;
                        scnt    <= '0;
                    end else if (wcnt == WLAST) begin
                        tmo_q <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (qual_on)
                        state_q <= ST_PARK;
                    else if (!pll_locked)
                        state_q <= ST_WAKE;
                    else if (scnt == SLAST)
                        state_q <= ST_RUN;
                    else
                        scnt <= scnt + 1'b1;
                end
                default: begin
                    if (qual_on)
                        state_q <= ST_PARK;
                end
            endcase
        end
    end

    assign state   = state_q;
    assign timeout = tmo_q;

    // R1: a new park state needs two consecutive qualified request samples
    a_r1_two_samples: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARK && $past(state_q) != ST_PARK) |-> ($past(req_sync, 1) && $past(req_sync, 2)));

    // R7: settle only begins while lock is reported
    a_r7_settle_needs_lock: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && $past(state_q) == ST_WAKE) |-> $past(pll_locked));

    // R8: timeout never rises while lock is present
    a_r8_timeout_without_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_q) |-> !$past(pll_locked));
endmodule

// File: rtl/clkout_pd_outstage.sv
module clkout_pd_outstage
    import clkout_pd_pkg::*;
#(
    parameter int PAIRS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_t       state,
    input  logic             float_mode,
    output logic [PAIRS-1:0] tru_oe,
    output logic [PAIRS-1:0] cmp_oe,
    output logic [PAIRS-1:0] tru_hi,
    output logic [PAIRS-1:0] cmp_hi
);
    leg_drive_t target;
    assign target = drive_for(state, float_mode);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        leg_drive_t drv_q;
        always_ff @(negedge clk) begin
            if (rst)
                drv_q <= park_drive(float_mode);
            else
                drv_q <= target;
        end
        assign tru_oe[p] = drv_q.toe;
        assign cmp_oe[p] = drv_q.coe;
        assign tru_hi[p] = drv_q.thi;
        assign cmp_hi[p] = drv_q.chi;
    end

    // R10: running pattern once run has been held across an edge
    a_r10_run_pattern: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN) |->
        (&tru_oe && &cmp_oe && !(|tru_hi) && !(|cmp_hi)));

    // R3: parked with true leg held high
    a_r3_park_hold_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK && $past(state) == ST_PARK && !float_mode && $stable(float_mode)) |->
        (&tru_oe && &tru_hi && !(|cmp_oe) && !(|cmp_hi)));

    // R4: parked with both legs released
    a_r4_park_float: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK && $past(state) == ST_PARK && float_mode && $stable(float_mode)) |->
        !(|{tru_oe, cmp_oe, tru_hi, cmp_hi}));

    // R6: wake in float mode drives every leg high
    a_r6_wake_all_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && $past(state) == ST_WAKE && float_mode && $stable(float_mode)) |->
        (&tru_oe && &cmp_oe && &tru_hi && &cmp_hi));

    // R10: all pairs agree
    a_r10_pairs_agree: assert property (@(posedge clk) disable iff (rst)
        ((tru_oe == '0 || tru_oe == '1) && (cmp_oe == '0 || cmp_oe == '1) &&
         (tru_hi == '0 || tru_hi == '1) && (cmp_hi == '0 || cmp_hi == '1)));
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
    import clkout_pd_pkg::*;
#(
    parameter int PAIRS        = 4,
    parameter int WAKE_MAX_CYC = 100000,
    parameter int SETTLE_CYC   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_pin,
    input  logic             park_float,
    input  logic             pd_active_high,
    input  logic             pll_locked,
    output logic [PAIRS-1:0] tru_oe,
    output logic [PAIRS-1:0] cmp_oe,
    output logic [PAIRS-1:0] tru_hi,
    output logic [PAIRS-1:0] cmp_hi,
    output logic             wake_timeout
);
    logic       req_raw;
    logic       req_sync;
    seq_state_t state;

    // R5: polarity selection ahead of the synchronizer
    assign req_raw = pd_active_high ? pd_pin : ~pd_pin;

    clkout_pd_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .req_async(req_raw),
        .req_sync (req_sync)
    );

    clkout_pd_fsm #(
        .WAKE_MAX_CYC(WAKE_MAX_CYC),
        .SETTLE_CYC  (SETTLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_sync  (req_sync),
        .pll_locked(pll_locked),
        .state     (state),
        .timeout   (wake_timeout)
    );

    clkout_pd_outstage #(
        .PAIRS(PAIRS)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .float_mode(park_float),
        .tru_oe    (tru_oe),
        .cmp_oe    (cmp_oe),
        .tru_hi    (tru_hi),
        .cmp_hi    (cmp_hi)
    );
endmodule

// File: tb/clkout_pd_seq_bench.sv
`timescale 1ns/1ps
module clkout_pd_seq_bench;
    localparam int PAIRS = 4;
    localparam int WMAX  = 40;
    localparam int SETL  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_pin = 1'b0;
    logic park_float = 1'b0;
    logic pd_active_high = 1'b1;
    logic pll_locked = 1'b1;
    logic [PAIRS-1:0] tru_oe, cmp_oe, tru_hi, cmp_hi;
    logic wake_timeout;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clkout_pd_seq #(.PAIRS(PAIRS), .WAKE_MAX_CYC(WMAX), .SETTLE_CYC(SETL)) u_clkout_pd_seq (
        .clk(clk), .rst(rst), .pd_pin(pd_pin), .park_float(park_float),
        .pd_active_high(pd_active_high), .pll_locked(pll_locked),
        .tru_oe(tru_oe), .cmp_oe(cmp_oe), .tru_hi(tru_hi), .cmp_hi(cmp_hi),
        .wake_timeout(wake_timeout)
    );

    // nibble order {tru_oe, cmp_oe, tru_hi, cmp_hi}
    localparam logic [3:0] P_RUN  = 4'b1100;
    localparam logic [3:0] P_HOLD = 4'b1010;
    localparam logic [3:0] P_OFF  = 4'b0000;
    localparam logic [3:0] P_HIGH = 4'b1111;

    // {park_float, pd_active_high, park pattern, wake pattern}
    localparam logic [9:0] VEC [4] = '{
        {1'b0, 1'b1, P_HOLD, P_HOLD},
        {1'b1, 1'b1, P_OFF,  P_HIGH},
        {1'b0, 1'b0, P_HOLD, P_HOLD},
        {1'b1, 1'b0, P_OFF,  P_HIGH}
    };

    task automatic check_pat(input string req, input logic [3:0] e);
        logic [4*PAIRS-1:0] act, exp;
        act = {tru_oe, cmp_oe, tru_hi, cmp_hi};
        exp = {{PAIRS{e[3]}}, {PAIRS{e[2]}}, {PAIRS{e[1]}}, {PAIRS{e[0]}}};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s outputs actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive the pin to request (1) or release (0) in the current polarity
    task automatic set_req(input logic on);
        pd_pin = pd_active_high ? on : ~on;
    endtask

    task automatic after_neg(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        after_neg(3);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        after_neg(1);
        for (int i = 0; i < 4; i++) begin
            park_float     = VEC[i][9];
            pd_active_high = VEC[i][8];
            pll_locked     = 1'b1;
            set_req(1'b0);
            rst = 1'b1;
            after_neg(3);
            check_pat("R9 reset parked", VEC[i][7:4]);
            rst = 1'b0;
            after_neg(SETL + 10);
            check_pat("R10 running after reset with lock", P_RUN);
            // R5 R2: assert request in this polarity
            set_req(1'b1);
            repeat (4) @(posedge clk);
            #1;
            check_pat("R2 old state before falling edge", P_RUN);
            @(negedge clk); #1;
            check_pat(VEC[i][9] ? "R4 R5 parked float" : "R3 R5 parked hold high", VEC[i][7:4]);
            pll_locked = 1'b0;
            set_req(1'b0);
            repeat (4) @(posedge clk);
            @(negedge clk); #1;
            check_pat("R6 wake pattern", VEC[i][3:0]);
            after_neg(8);
            check_pat("R7 no run without lock", VEC[i][3:0]);
            pll_locked = 1'b1;
            after_neg(SETL + 4);
            check_pat("R7 run after lock and settle", P_RUN);
        end

        // R1: single-cycle pulse ignored
        park_float = 1'b0; pd_active_high = 1'b1; pll_locked = 1'b1;
        set_req(1'b0);
        do_reset();
        after_neg(SETL + 10);
        set_req(1'b1);
        after_neg(1);
        set_req(1'b0);
        repeat (8) begin
            after_neg(1);
            check_pat("R1 one-cycle pulse ignored", P_RUN);
        end

        // R7: exact settle timing
        set_req(1'b1);
        after_neg(8);
        set_req(1'b0);
        repeat (4 + SETL) @(posedge clk);
        @(negedge clk); #1;
        check_pat("R7 still settling", P_HOLD);
        @(posedge clk);
        @(negedge clk); #1;
        check_pat("R7 run at settle end", P_RUN);

        // R7: lock lost during settle
        set_req(1'b1);
        after_neg(8);
        set_req(1'b0);
        repeat (6) @(posedge clk);
        #1;
        pll_locked = 1'b0;
        after_neg(3 * SETL);
        check_pat("R7 lock loss returns to wait", P_HOLD);
        pll_locked = 1'b1;
        after_neg(SETL + 4);
        check_pat("R7 run after lock regained", P_RUN);

        // R8: timeout exact count and stickiness
        set_req(1'b1);
        after_neg(8);
        pll_locked = 1'b0;
        set_req(1'b0);
        repeat (4) @(posedge clk);
        #1;
        check_bit("R8 timeout clear at wake entry", wake_timeout, 1'b0);
        repeat (WMAX - 1) @(posedge clk);
        #1;
        check_bit("R8 timeout not yet", wake_timeout, 1'b0);
        @(posedge clk); #1;
        check_bit("R8 timeout raised", wake_timeout, 1'b1);
        @(negedge clk); #1;
        check_pat("R8 outputs held during timeout", P_HOLD);
        pll_locked = 1'b1;
        after_neg(SETL + 4);
        check_pat("R8 run after late lock", P_RUN);
        check_bit("R8 timeout sticky", wake_timeout, 1'b1);
        set_req(1'b1);
        after_neg(8);
        set_req(1'b0);
        after_neg(5);
        check_bit("R8 timeout cleared by release", wake_timeout, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule